// File: doc/BRIEF.md
# Ternary-match operand fault checker

This block sits next to a 32-bit adder and inspects every operand pair the adder receives. It holds a small table of ternary cubes. A cube is a bit pattern in which each position is 0, 1 or don't-care. Together the cubes describe the operand values known to excite a fault in the adder, plus any extra cubes deliberately added so that the table stays small. When the current operand pair falls inside any stored cube, the block raises a registered recovery flag. The flag tells the surrounding pipeline to redo the operation on a healthy path. The checker only taps the operand wires, so it adds no gates to the adder's own path.

The table is filled once after power-up through a sequential load port. Each write strobe stores one cube, given as a value word and a care mask, into the next free row. There is no row address. Later, a clear command empties the table so that a revised set of cubes can be streamed in. The number of rows is a parameter; budgets such as 32, 48, 64 or 128 are typical.

Top module: `tcam_operand_checker`

## Requirements
- R1: A stored row matches the key when every key bit whose care-mask bit is 1 equals the corresponding value bit. A key bit whose care-mask bit is 0 is don't-care and matches both 0 and 1.
- R2: Each write strobe, given while clear is low and the table is not full, stores the presented value and care mask into the row at the write pointer. The pointer starts at row 0 and advances by exactly one row per accepted strobe.
- R3: The match key is op_a in the upper half and op_b in the lower half. Bit k of the value and of the care mask lines up with key bit k, so key bit OPW+j is op_a[j] and key bit j is op_b[j].
- R4: After ENTRIES accepted writes, table_full is 1. Later write strobes store nothing and the pointer does not wrap around.
- R5: When reset is low (synchronously) or ld_clear is high, all rows become invalid, the pointer returns to 0 and table_full goes to 0. If ld_clear and ld_we are high in the same cycle, the clear wins and nothing is stored.
- R6: A row that has not been written since the last reset or clear never matches. With an empty table, recover stays 0 for every key.
- R7: recover is a register. It is 1 in the cycle after a cycle in which op_valid was 1 and the key matched at least one valid row. It is 0 in the cycle after any cycle in which op_valid was 0.
- R8: A check in the same cycle as a write or a clear uses the table contents as they were before that write or clear.
- R9: A match on any single valid row is enough to raise recover. All valid rows are compared in parallel and their results are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operand pair is presented for checking |
| op_a | input | OPW | Adder operand A (upper half of the key) |
| op_b | input | OPW | Adder operand B (lower half of the key) |
| ld_clear | input | 1 | Empty the table and rewind the write pointer |
| ld_we | input | 1 | Store one cube into the next free row |
| ld_value | input | 2*OPW | Cube value bits |
| ld_care | input | 2*OPW | Cube care mask, where 1 means the bit must match |
| recover | output | 1 | Registered recovery request |
| table_full | output | 1 | Every row has been written |

## Verification
The hardest cases to reach from the ports are the collisions. In one, a load or clear lands in the same cycle as an operand check. In the other, a write strobe arrives after the table is already full. In both cases the wrong behaviour can only be seen one operation later. The bench reaches them with cubes whose care mask is all zeros, so the cube matches every key. It writes such a cube in the same cycle as a check and expects no hit, then expects a hit on the next check. It clears under a check and expects a hit, then expects none afterwards. It offers the same all-match cube as the fifth write to a full four-row table, then sweeps all 256 keys to confirm that the table was left untouched.

// File: rtl/tcam_chk_pkg.sv
// Package: shared defaults and width helpers for the operand checker.
// Assumes: callers pass positive sizes.
package tcam_chk_pkg;
    localparam int DEF_OPW     = 32;
    localparam int DEF_ENTRIES = 32;

    // Width of the match key built from two operands.
    function automatic int key_width(input int opw);
        return 2 * opw;
    endfunction

    // Width of a pointer that can also hold the value n (the full state).
    function automatic int ptr_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cube_loader.sv
// Module: cube_loader
// Sequential write pointer for the cube table. It turns a write strobe into a
// one-hot row enable with no address decoder input, and it reports when the
// table is full. A clear takes priority over a write in the same cycle.
// Assumes: ENTRIES >= 1, synchronous active-low reset.
module cube_loader #(
    parameter int ENTRIES = tcam_chk_pkg::DEF_ENTRIES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               we,
    output logic [ENTRIES-1:0] row_we,
    output logic               full
);
    localparam int PW = tcam_chk_pkg::ptr_width(ENTRIES);

    logic [PW-1:0] ptr_q;
    logic          accept;

    assign full   = (ptr_q == PW'(ENTRIES));
    assign accept = we && !clear && !full;

    // Advance the pointer on accepted writes; rewind on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ptr_q <= '0;
        else if (accept)     ptr_q <= ptr_q + PW'(1);
    end

    // One enable per row, selected by the pointer.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_en
        assign row_we[i] = accept && (ptr_q == PW'(i));
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear && !full) |=> (ptr_q == $past(ptr_q) + PW'(1))); // R2
    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear) |=> (full && $stable(ptr_q))); // R4
    AST_CLEAR_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr_q == '0 && !full)); // R5
    AST_ROW_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we)); // R2
endmodule

// File: rtl/cube_row.sv
// Module: cube_row
// One ternary row. It stores a value word, a care mask and a valid bit, and it
// compares them against the key with no clock in between. Bits whose care bit
// is 0 are don't-care. An invalid row never hits.
// Assumes: clear has priority over we (the loader already guarantees this).
module cube_row #(
    parameter int KW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          we,
    input  logic [KW-1:0] wval,
    input  logic [KW-1:0] wcare,
    input  logic [KW-1:0] key,
    output logic          hit
);
    logic          valid_q;
    logic [KW-1:0] val_q;
    logic [KW-1:0] care_q;

    // Hold the row contents; invalidate on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= 1'b0;
            val_q   <= '0;
            care_q  <= '0;
        end else if (we) begin
            valid_q <= 1'b1;
            val_q   <= wval;
            care_q  <= wcare;
        end
    end

    // Ternary compare: a hit needs a valid row and no mismatch on a cared bit.
    always_comb begin
        hit = valid_q && (((key ^ val_q) & care_q) == '0);
    end

    AST_CLEAR_EMPTIES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hit); // R6
endmodule

// File: rtl/tcam_operand_checker.sv
// Module: tcam_operand_checker
// Top level. It forms the key {op_a, op_b}, compares it against every loaded
// cube in parallel and registers the OR of the row hits, qualified by
// op_valid, as the recovery flag. It only taps the operands and never drives
// the adder's path.
// Assumes: synchronous active-low reset; a check sees the table as it was
// before any write or clear in the same cycle.
module tcam_operand_checker #(
    parameter int OPW     = tcam_chk_pkg::DEF_OPW,
    parameter int ENTRIES = tcam_chk_pkg::DEF_ENTRIES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [OPW-1:0]        op_a,
    input  logic [OPW-1:0]        op_b,
    input  logic                  ld_clear,
    input  logic                  ld_we,
    input  logic [2*OPW-1:0]      ld_value,
    input  logic [2*OPW-1:0]      ld_care,
    output logic                  recover,
    output logic                  table_full
);
    localparam int KW = tcam_chk_pkg::key_width(OPW);

    logic [KW-1:0]      key;
    logic [ENTRIES-1:0] row_we;
    logic [ENTRIES-1:0] row_hit;
    logic               any_hit;

    assign key     = {op_a, op_b};
    assign any_hit = |row_hit;

    cube_loader #(.ENTRIES(ENTRIES)) u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ld_clear),
        .we     (ld_we),
        .row_we (row_we),
        .full   (table_full)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_row
        cube_row #(.KW(KW)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (ld_clear),
            .we    (row_we[i]),
            .wval  (ld_value),
            .wcare (ld_care),
            .key   (key),
            .hit   (row_hit[i])
        );
    end

    // Register the recovery request for the operation just presented.
    always_ff @(posedge clk) begin
        if (!rst_n) recover <= 1'b0;
        else        recover <= op_valid && any_hit;
    end

    AST_IDLE_NO_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !recover); // R7
    AST_ANY_ROW_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && row_hit != '0) |=> recover); // R9
    AST_NO_HIT_NO_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (row_hit == '0) |=> !recover); // R1
endmodule

// File: tb/test_tcam_operand_checker.sv
// Bench: a 4-row table with 4-bit operands (8-bit key), swept over every key.
module test_tcam_operand_checker;
    localparam int OPW = 4;
    localparam int N   = 4;
    localparam int KW  = 2 * OPW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           op_valid = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic           ld_clear = 1'b0;
    logic           ld_we = 1'b0;
    logic [KW-1:0]  ld_value = '0;
    logic [KW-1:0]  ld_care = '0;
    logic           recover;
    logic           table_full;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [KW-1:0] mv [N];
    logic [KW-1:0] mc [N];
    int            nv = 0;

    tcam_operand_checker #(.OPW(OPW), .ENTRIES(N)) i_tcam_operand_checker (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .ld_clear(ld_clear), .ld_we(ld_we), .ld_value(ld_value), .ld_care(ld_care),
        .recover(recover), .table_full(table_full)
    );

    always #4 clk = ~clk;

    function automatic bit model_hit(input logic [KW-1:0] k);
        bit h = 0;
        for (int i = 0; i < nv; i++)
            if (((k ^ mv[i]) & mc[i]) == '0) h = 1;
        return h;
    endfunction

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Present one operand pair, then sample recover one clock later.
    task automatic check_key(input logic [KW-1:0] k, input logic v,
                             input logic exp, input string tag);
        @(negedge clk);
        op_a = k[KW-1:OPW]; op_b = k[OPW-1:0]; op_valid = v;
        @(negedge clk);
        op_valid = 1'b0;
        expect_bit(tag, recover, exp);
    endtask

    task automatic load(input logic [KW-1:0] v, input logic [KW-1:0] c);
        @(negedge clk);
        ld_we = 1'b1; ld_value = v; ld_care = c;
        @(negedge clk);
        ld_we = 1'b0;
        if (nv < N) begin mv[nv] = v; mc[nv] = c; nv++; end
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 256; k++)
            check_key(k[KW-1:0], 1'b1, model_hit(k[KW-1:0]), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_bit("R5 reset recover", recover, 1'b0);
        expect_bit("R5 reset full", table_full, 1'b0);

        sweep("R6 empty table");

        // Row 0 cares only about A bits, row 1 only about B bits.
        load(8'b1000_0000, 8'b1010_0000);
        load(8'b0000_0110, 8'b0000_1111);
        sweep("R1 R3 R9 two rows");
        check_key(8'h86, 1'b0, 1'b0, "R7 valid low");
        check_key(8'h86, 1'b1, 1'b1, "R9 both rows hit");

        load(8'h5A, 8'hFF);
        expect_bit("R4 not yet full", table_full, 1'b0);
        load(8'h11, 8'h11);
        expect_bit("R4 full", table_full, 1'b1);
        sweep("R1 four rows");
        load(8'h00, 8'h00);  // match-all cube offered to a full table
        expect_bit("R4 still full", table_full, 1'b1);
        sweep("R4 extra write ignored");

        // Clear while checking: the check still sees the old table.
        @(negedge clk);
        ld_clear = 1'b1; op_valid = 1'b1; op_a = 4'h8; op_b = 4'h0;
        @(negedge clk);
        ld_clear = 1'b0; op_valid = 1'b0; nv = 0;
        expect_bit("R8 clear under check", recover, 1'b1);
        expect_bit("R5 clear empties full", table_full, 1'b0);
        check_key(8'h80, 1'b1, 1'b0, "R5 cleared table");

        // Write the match-all cube during a check: no hit yet, hit afterwards.
        @(negedge clk);
        ld_we = 1'b1; ld_value = '0; ld_care = '0;
        op_valid = 1'b1; op_a = 4'h3; op_b = 4'hC;
        @(negedge clk);
        ld_we = 1'b0; op_valid = 1'b0;
        mv[0] = '0; mc[0] = '0; nv = 1;
        expect_bit("R8 write under check", recover, 1'b0);
        check_key(8'h3C, 1'b1, 1'b1, "R2 row 0 written");

        // Clear and write together: the clear wins.
        @(negedge clk);
        ld_clear = 1'b1; ld_we = 1'b1; ld_value = '0; ld_care = '0;
        @(negedge clk);
        ld_clear = 1'b0; ld_we = 1'b0; nv = 0;
        check_key(8'hE7, 1'b1, 1'b0, "R5 clear beats write");

        // Reload after clearing, starting again at row 0.
        load(8'hF0, 8'hF0);
        sweep("R2 reload");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule